// File: doc/BRIEF.md
# Daisy-Chain Vectored Interrupt Prioritiser

This block arbitrates interrupts for a two-channel serial peripheral. It has six request sources: receive, transmit and external/status for channel A and for channel B. It takes part in a system-wide priority chain through an enable-in and an enable-out line. It pulls an active-low request line while an enabled source is waiting. During the acknowledge cycle it supplies an 8-bit vector, and it can rewrite three bits of that vector with a code that names the winning source.

The block keeps two records for each source: a pending flag and an under-service latch. It watches opcode fetches on the data bus. When it sees a two-byte return-from-interrupt sequence, it retires only the service latch that belongs to it. All logic is synchronous to one system clock. The bus strobes (M1, IORQ, RD) are active-low levels that the block samples at each clock edge.

Top module: `irq_daisy_ctrl`

## Requirements
- R1: After reset no source is pending or under service: `int_n` is 1, `vec_oe` is 0 and `ieo` equals `iei`.
- R2: Fixed priority, highest first, by `src_req` bit: 0 A receive, 1 A transmit, 2 A external/status, 3 B receive, 4 B transmit, 5 B external/status. The vector always names the highest-priority eligible source.
- R3: `ieo` is low whenever any source is under service or any enabled source is pending. Otherwise it equals `iei`.
- R4: Pending flags do not change while `m1_n` is low. A request pulse that arrives in that window takes effect at the first clock edge at which `m1_n` is high.
- R5: An acknowledge is `m1_n` and `iorq_n` both low while `iei` is high. At the first edge of an acknowledge, the block captures the vector and sets the winner's service latch. From the next cycle until the acknowledge ends, `vec_oe` is 1 with a stable `vec_out`. The winner's pending flag clears at the first edge after `m1_n` returns high. An acknowledge with `iei` low has no effect.
- R6: When `vec_mod_en` is 1, bits 3:1 of `vec_base` are replaced by a source code: A receive 110, A transmit 100, A external 101, B receive 010, B transmit 000, B external 001. The other bits pass through unchanged. When `vec_mod_en` is 0, the vector equals `vec_base`.
- R7: `int_n` is 0 exactly when `iei` is high and some source is pending, enabled in `src_en` and not masked. A source whose `src_en` bit is 0 neither requests nor holds `ieo` low.
- R8: A source under service masks itself and every source of lower priority. Sources of higher priority can still interrupt.
- R9: An opcode fetch (`m1_n` and `rd_n` low, `iorq_n` high) of 0xED, followed by a fetch of 0x4D while `iei` is high, clears the highest-priority service latch. A fetch of 0xED followed by any other byte clears nothing.
- R10: After a fetch of 0xED, and until the next fetch, pending sources that have not been acknowledged do not hold `ieo` low.
- R11: If no source is eligible at the acknowledge, the vector carries code 011 in bits 3:1 (when modification is enabled).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_req | input | 6 | Request pulses, one per source (bit 0 highest priority) |
| src_en | input | 6 | Per-source interrupt enable |
| m1_n | input | 1 | Machine cycle one strobe, active low |
| iorq_n | input | 1 | I/O request strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| dbus_in | input | 8 | Data bus as seen by the block (opcode watch) |
| iei | input | 1 | Daisy-chain enable in, active high |
| vec_base | input | 8 | Programmed interrupt vector |
| vec_mod_en | input | 1 | Source code replaces vector bits 3:1 when 1 |
| int_n | output | 1 | Interrupt request, active low |
| ieo | output | 1 | Daisy-chain enable out, active high |
| vec_out | output | 8 | Vector presented during acknowledge |
| vec_oe | output | 1 | Drive enable for `vec_out` onto the bus |

## Verification
The assertions assume that the bus strobes follow legal cycle shapes: an acknowledge never overlaps an opcode fetch, and a fetch always drops `iorq_n` high. They also assume that `iei` and the strobes are stable around the sampling edge. The stimulus keeps to these rules. It changes every input only on the falling clock edge. It builds each acknowledge and each fetch as a one-cycle low strobe followed by a release cycle. It never asserts `rd_n` and `iorq_n` together.

// File: rtl/irq_daisy_pkg.sv
package irq_daisy_pkg;
   localparam int SRC_COUNT = 6;
   localparam int CODE_W    = 3;
   localparam logic [CODE_W-1:0] CODE_IDLE = 3'b011;

   // bit order of sources = priority, index 0 highest
   function automatic logic [CODE_W-1:0] src_code(input int idx);
      logic [CODE_W-1:0] c;
      case (idx)
         0:       c = 3'b110;
         1:       c = 3'b100;
         2:       c = 3'b101;
         3:       c = 3'b010;
         4:       c = 3'b000;
         5:       c = 3'b001;
         default: c = CODE_IDLE;
      endcase
      return c;
   endfunction
endpackage

// File: rtl/irq_daisy_prio.sv
module irq_daisy_prio
   import irq_daisy_pkg::*;
#(
   parameter int NSRC      = SRC_COUNT,
   parameter int VEC_W     = 8,
   parameter int MOD_LSB   = 1,
   parameter bit ALLOW_MOD = 1'b1
) (
   input  logic [NSRC-1:0]  pend,
   input  logic [NSRC-1:0]  en,
   input  logic [NSRC-1:0]  ius,
   input  logic [VEC_W-1:0] base,
   input  logic             mod_en,
   output logic [NSRC-1:0]  eligible,
   output logic [NSRC-1:0]  grant,
   output logic [VEC_W-1:0] vector
);
   localparam logic [VEC_W-1:0] FIELD_MASK = VEC_W'({CODE_W{1'b1}}) << MOD_LSB;

   logic [NSRC-1:0]   blocked;
   logic [NSRC-1:0]   taken;
   logic [CODE_W-1:0] code_parts [NSRC];
   logic [CODE_W-1:0] code;

   generate
      if (MOD_LSB + CODE_W > VEC_W) begin : g_bad_field
         $error("vector code field does not fit the vector width");
      end
      if (NSRC != SRC_COUNT) begin : g_bad_count
         $error("source count must match the code table");
      end

      for (genvar i = 0; i < NSRC; i++) begin : g_chain
         if (i == 0) begin : g_head
            assign blocked[i] = ius[i];
            assign taken[i]   = eligible[i];
            assign grant[i]   = eligible[i];
         end else begin : g_tail
            assign blocked[i] = blocked[i-1] | ius[i];
            assign taken[i]   = taken[i-1] | eligible[i];
            assign grant[i]   = eligible[i] & ~taken[i-1];
         end
         assign eligible[i]   = pend[i] & en[i] & ~blocked[i];
         assign code_parts[i] = grant[i] ? src_code(i) : '0;
      end
   endgenerate

   always_comb begin
      code = (|eligible) ? '0 : CODE_IDLE;
      for (int k = 0; k < NSRC; k++) code = code | code_parts[k];
   end

   generate
      if (ALLOW_MOD) begin : g_mod
         assign vector = mod_en
            ? ((base & ~FIELD_MASK) | (VEC_W'(code) << MOD_LSB))
            : base;
      end else begin : g_plain
         assign vector = base;
      end
   endgenerate
endmodule

// File: rtl/irq_daisy_state.sv
module irq_daisy_state #(
   parameter int NSRC = 6
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] src_req,
   input  logic            m1_n,
   input  logic            ack_first,
   input  logic [NSRC-1:0] grant,
   input  logic            reti_hit,
   output logic [NSRC-1:0] pend_q,
   output logic [NSRC-1:0] ius_q
);
   logic [NSRC-1:0] hold_q;
   logic [NSRC-1:0] clr_q;
   logic [NSRC-1:0] ius_set;
   logic [NSRC-1:0] ius_clr;

   assign ius_set = ack_first ? grant : '0;
   // lowest set bit is the highest-priority latch
   assign ius_clr = reti_hit ? (ius_q & ~(ius_q - NSRC'(1))) : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q <= '0;
         hold_q <= '0;
         clr_q  <= '0;
         ius_q  <= '0;
      end else begin
         if (m1_n) begin
            pend_q <= (pend_q & ~clr_q) | src_req | hold_q;
            hold_q <= '0;
            clr_q  <= '0;
         end else begin
            hold_q <= hold_q | src_req;
            clr_q  <= clr_q | ius_set;
         end
         ius_q <= (ius_q | ius_set) & ~ius_clr;
      end
   end

   assert_pend_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !m1_n |=> $stable(pend_q));

   assert_ius_only_by_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !ack_first |=> ($countones(ius_q) <= $countones($past(ius_q))));

   assert_grant_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));
endmodule

// File: rtl/irq_daisy_opwatch.sv
module irq_daisy_opwatch #(
   parameter int          BUS_W  = 8,
   parameter logic [7:0]  PREFIX = 8'hED,
   parameter logic [7:0]  RET_OP = 8'h4D
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             m1_n,
   input  logic             rd_n,
   input  logic             iorq_n,
   input  logic [BUS_W-1:0] dbus,
   input  logic             iei,
   output logic             ed_seen,
   output logic             reti_hit
);
   generate
      if (BUS_W != 8) begin : g_bad_bus
         $error("opcode watch expects an 8-bit bus");
      end
   endgenerate

   logic fetch_now;
   logic fetch_q;
   logic fetch_first;

   assign fetch_now   = !m1_n && !rd_n && iorq_n;
   assign fetch_first = fetch_now && !fetch_q;
   assign reti_hit    = fetch_first && ed_seen && (dbus == RET_OP) && iei;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fetch_q <= 1'b0;
         ed_seen <= 1'b0;
      end else begin
         fetch_q <= fetch_now;
         if (fetch_first) ed_seen <= (dbus == PREFIX);
      end
   end

   assert_prefix_only_on_fetch_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (m1_n || !rd_n == 1'b0) |=> $stable(ed_seen));

   assert_reti_needs_prefix_R9: assert property (@(posedge clk) disable iff (!rst_n)
      reti_hit |-> (ed_seen && !m1_n));
endmodule

// File: rtl/irq_daisy_ctrl.sv
module irq_daisy_ctrl
   import irq_daisy_pkg::*;
#(
   parameter int NSRC      = SRC_COUNT,
   parameter int VEC_W     = 8,
   parameter int MOD_LSB   = 1,
   parameter bit ALLOW_MOD = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NSRC-1:0]  src_req,
   input  logic [NSRC-1:0]  src_en,
   input  logic             m1_n,
   input  logic             iorq_n,
   input  logic             rd_n,
   input  logic [VEC_W-1:0] dbus_in,
   input  logic             iei,
   input  logic [VEC_W-1:0] vec_base,
   input  logic             vec_mod_en,
   output logic             int_n,
   output logic             ieo,
   output logic [VEC_W-1:0] vec_out,
   output logic             vec_oe
);
   logic [NSRC-1:0]  pend_q;
   logic [NSRC-1:0]  ius_q;
   logic [NSRC-1:0]  eligible;
   logic [NSRC-1:0]  grant;
   logic [VEC_W-1:0] vector;
   logic             ack_now;
   logic             ack_q;
   logic             ack_first;
   logic             ed_seen;
   logic             reti_hit;
   logic [VEC_W-1:0] vec_q;

   assign ack_now   = !m1_n && !iorq_n && iei;
   assign ack_first = ack_now && !ack_q;

   irq_daisy_prio #(
      .NSRC(NSRC), .VEC_W(VEC_W), .MOD_LSB(MOD_LSB), .ALLOW_MOD(ALLOW_MOD)
   ) u_prio (
      .pend(pend_q), .en(src_en), .ius(ius_q), .base(vec_base),
      .mod_en(vec_mod_en), .eligible(eligible), .grant(grant), .vector(vector)
   );

   irq_daisy_state #(.NSRC(NSRC)) u_state (
      .clk(clk), .rst_n(rst_n), .src_req(src_req), .m1_n(m1_n),
      .ack_first(ack_first), .grant(grant), .reti_hit(reti_hit),
      .pend_q(pend_q), .ius_q(ius_q)
   );

   irq_daisy_opwatch #(.BUS_W(VEC_W)) u_opwatch (
      .clk(clk), .rst_n(rst_n), .m1_n(m1_n), .rd_n(rd_n), .iorq_n(iorq_n),
      .dbus(dbus_in), .iei(iei), .ed_seen(ed_seen), .reti_hit(reti_hit)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ack_q <= 1'b0;
         vec_q <= '0;
      end else begin
         ack_q <= ack_now;
         if (ack_first) vec_q <= vector;
      end
   end

   assign vec_out = vec_q;
   assign vec_oe  = ack_q && ack_now;
   assign int_n   = !((|eligible) && iei);
   assign ieo     = iei && !(|ius_q) && (ed_seen || !(|(pend_q & src_en)));

   assert_ieo_blocked_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (|ius_q) |-> !ieo);

   assert_int_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !iei |-> int_n);

   assert_vec_only_in_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
      vec_oe |-> (!m1_n && !iorq_n && iei));

   assert_vec_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (vec_oe && $past(vec_oe)) |-> $stable(vec_out));

   assert_masked_no_int_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ius_q[0] && !(|(pend_q & src_en & ~ius_q))) |-> int_n);
endmodule

// File: tb/irq_daisy_ctrl_bench.sv
`timescale 1ns/1ps
module irq_daisy_ctrl_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [5:0] src_req = '0;
   logic [5:0] src_en = '1;
   logic       m1_n = 1'b1;
   logic       iorq_n = 1'b1;
   logic       rd_n = 1'b1;
   logic [7:0] dbus_in = '0;
   logic       iei = 1'b1;
   logic [7:0] vec_base = 8'h5F;
   logic       vec_mod_en = 1'b1;
   logic       int_n;
   logic       ieo;
   logic [7:0] vec_out;
   logic       vec_oe;

   int nchk = 0;
   int nerr = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   irq_daisy_ctrl u_irq_daisy_ctrl (
      .clk(clk), .rst_n(rst_n), .src_req(src_req), .src_en(src_en),
      .m1_n(m1_n), .iorq_n(iorq_n), .rd_n(rd_n), .dbus_in(dbus_in),
      .iei(iei), .vec_base(vec_base), .vec_mod_en(vec_mod_en),
      .int_n(int_n), .ieo(ieo), .vec_out(vec_out), .vec_oe(vec_oe)
   );

   // rows: request mask, modification enable, expected vector (base 0x5F)
   localparam logic [5:0] TV_REQ [10] = '{6'b000001, 6'b000010, 6'b000100,
      6'b001000, 6'b010000, 6'b100000, 6'b001010, 6'b110100, 6'b000000, 6'b000001};
   localparam logic TV_MOD [10] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1,
      1'b1, 1'b1, 1'b1, 1'b0};
   localparam logic [7:0] TV_EXP [10] = '{8'h5D, 8'h59, 8'h5B, 8'h55, 8'h51,
      8'h53, 8'h59, 8'h5B, 8'h57, 8'h5F};

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; src_req = '0; src_en = '1; m1_n = 1'b1; iorq_n = 1'b1;
      rd_n = 1'b1; iei = 1'b1; vec_mod_en = 1'b1;
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic pulse(input logic [5:0] m);
      @(negedge clk); src_req = m;
      @(negedge clk); src_req = '0;
   endtask

   task automatic do_ack(output logic [7:0] v, output logic oe);
      @(negedge clk); m1_n = 1'b0; iorq_n = 1'b0;
      @(negedge clk); v = vec_out; oe = vec_oe; m1_n = 1'b1; iorq_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic fetch(input logic [7:0] op);
      @(negedge clk); m1_n = 1'b0; rd_n = 1'b0; dbus_in = op;
      @(negedge clk); m1_n = 1'b1; rd_n = 1'b1;
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         nchk++; nerr++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", nerr, nchk);
         $finish;
      end
   end

   initial begin : main
      logic [7:0] v;
      logic       oe;
      do_reset();
      @(negedge clk);
      chk("R1 int_n", int_n, 1'b1);
      chk("R1 ieo", ieo, 1'b1);
      chk("R1 vec_oe", vec_oe, 1'b0);

      // table walk: vector codes (R6), priority (R2), idle code (R11)
      for (int k = 0; k < 10; k++) begin
         do_reset();
         vec_mod_en = TV_MOD[k];
         if (TV_REQ[k] != 0) pulse(TV_REQ[k]);
         do_ack(v, oe);
         chk(k < 6 ? "R6 vector" : (k < 8 ? "R2 vector" : (k == 8 ? "R11 vector" : "R6 plain")), v, TV_EXP[k]);
         chk("R5 vec_oe", oe, 1'b1);
      end

      // R7 and R3 basic request
      do_reset();
      pulse(6'b000001);
      chk("R7 int_n low", int_n, 1'b0);
      chk("R3 ieo low pending", ieo, 1'b0);
      @(negedge clk); iei = 1'b0; #0.5;
      chk("R7 iei low", int_n, 1'b1);
      chk("R3 ieo iei low", ieo, 1'b0);
      // R5 acknowledge ignored while iei low
      do_ack(v, oe);
      chk("R5 ack ignored oe", oe, 1'b0);
      iei = 1'b1; #0.5;
      chk("R5 still pending", int_n, 1'b0);
      do_ack(v, oe);
      chk("R5 ack vector", v, 8'h5D);
      chk("R3 ieo in service", ieo, 1'b0);
      fetch(8'hED); fetch(8'h4D);
      @(negedge clk);
      chk("R9 ieo after return", ieo, 1'b1);
      chk("R5 pending cleared", int_n, 1'b1);

      // R4 freeze during M1
      do_reset();
      @(negedge clk); m1_n = 1'b0; rd_n = 1'b0; dbus_in = 8'h00; src_req = 6'b000010;
      @(negedge clk); src_req = '0;
      @(negedge clk);
      chk("R4 frozen", int_n, 1'b1);
      m1_n = 1'b1; rd_n = 1'b1;
      @(negedge clk);
      chk("R4 applied", int_n, 1'b0);

      // R7 disabled source
      do_reset();
      src_en = 6'b111110;
      pulse(6'b000001);
      chk("R7 disabled int_n", int_n, 1'b1);
      chk("R7 disabled ieo", ieo, 1'b1);
      src_en = '1; #0.5;
      chk("R7 enabled", int_n, 1'b0);

      // R8 masking and R9 nested returns
      do_reset();
      pulse(6'b001000);
      do_ack(v, oe);
      chk("R8 first vector", v, 8'h55);
      pulse(6'b010000);
      chk("R8 lower masked", int_n, 1'b1);
      pulse(6'b000010);
      chk("R8 higher passes", int_n, 1'b0);
      do_ack(v, oe);
      chk("R8 nested vector", v, 8'h59);
      fetch(8'hED); fetch(8'h00);
      fetch(8'hED); fetch(8'h4D);
      @(negedge clk);
      chk("R9 one latch cleared", int_n, 1'b1);
      fetch(8'hED); fetch(8'h4D);
      @(negedge clk);
      chk("R9 second latch cleared", int_n, 1'b0);

      // R10 prefix releases ieo
      do_reset();
      pulse(6'b000100);
      chk("R10 ieo before", ieo, 1'b0);
      fetch(8'hED);
      chk("R10 ieo after prefix", ieo, 1'b1);
      fetch(8'h00);
      chk("R10 ieo after other", ieo, 1'b0);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end
endmodule